// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block steers instruction fetch before any decode has happened. Every fetch address is looked up in a direct-mapped table of 2^IDX_W slots. Each slot keeps a valid flag, the complete address of a control-transfer instruction as its tag, a predicted destination and a small saturating confidence counter. When the tag equals the fetch address and the counter leans towards taken, the block proposes the stored destination as the next fetch address. In every other case it proposes the sequential address, fetch address plus four.

Because the tag is the whole address, an ordinary instruction that shares a slot index with a branch never picks up that branch's destination. Later in the pipe, the execute stage reports each resolved instruction on a resolution port. The report carries whether it is a control transfer, its real direction and destination, and the next address that was predicted for it at fetch time. The block compares the real next address with the predicted one and raises a one-cycle redirect carrying the correct address whenever they differ. It then trains, allocates or leaves the slot. Table writes happen only from this port, so the table only learns after execute.

Top module: `fetch_target_buf`

## Requirements
- R1: After a synchronous reset every slot is invalid, so each fetch gets `lk_taken`=0 and `lk_next_pc` = fetch address + 4 until a taken control transfer is resolved. `lk_valid` and `redir_valid` are 0 while reset is asserted.
- R2: The slot index is fetch address bits [IDX_W+1:2] and the tag is the full address. A fetch at a different address that maps to an occupied slot does not match.
- R3: A fetch presented with `fetch_valid`=1 at one rising edge produces its result after that edge: `lk_valid`=1, `lk_pc` equal to the fetch address, and, on a tag match whose counter MSB is 1, `lk_taken`=1 and `lk_next_pc` equal to the stored destination.
- R4: A tag match whose counter MSB is 0 gives `lk_taken`=0 and `lk_next_pc` = address + 4.
- R5: A resolved control transfer (`rs_is_cti`=1) that is taken and misses the table overwrites its slot with its address, its destination and the counter value binary 10 (weakly taken).
- R6: A resolved control transfer that is not taken and misses the table writes nothing; whatever the slot held stays visible to fetch.
- R7: A resolution with `rs_is_cti`=0 never creates or modifies a slot.
- R8: A resolved control transfer that hits its slot moves the counter up by one if taken and down by one if not, saturating at 0 and at the all-ones value. A taken hit also replaces the stored destination with the reported one.
- R9: One cycle after a resolution, `redir_valid` is 1 exactly when the real next address differs from `rs_pred_next`. The real next address is `rs_target` for a taken control transfer and address + 4 otherwise, and `redir_pc` carries it.
- R10: A table write caused by a resolution at edge t is visible to fetches presented at edge t+2 or later, not to a fetch at edge t+1. Back-to-back resolutions of the same slot each see all earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_pc | input | PC_W | Fetch address |
| lk_valid | output | 1 | Lookup result present |
| lk_pc | output | PC_W | Fetch address the result belongs to |
| lk_taken | output | 1 | Redirect fetch to the stored destination |
| lk_next_pc | output | PC_W | Proposed next fetch address |
| rs_valid | input | 1 | A resolved instruction is reported |
| rs_pc | input | PC_W | Address of the resolved instruction |
| rs_is_cti | input | 1 | The instruction is a branch or jump |
| rs_taken | input | 1 | Real direction |
| rs_target | input | PC_W | Real destination when taken |
| rs_pred_next | input | PC_W | Next address that was predicted at fetch |
| redir_valid | output | 1 | Prediction was wrong; kill and refetch |
| redir_pc | output | PC_W | Correct next fetch address |

## Verification
The assertions assume that a reported resolution is self-consistent. They take `rs_target` as meaningful only when `rs_is_cti` and `rs_taken` are both set, and they expect addresses to be word-aligned, so that a stored tag always indexes its own slot. The bench draws addresses from a small word-aligned pool in which half the addresses alias the other half's slots, and it draws destinations from a separate aligned range. The predicted-next value it reports is sometimes the model's own lookup answer and sometimes a deliberately wrong address, so both the redirect and the no-redirect paths are exercised under legal inputs.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

  // What the resolution stage does to the indexed slot.
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_TRAIN = 2'd1,
    ACT_ALLOC = 2'd2
  } ftb_act_e;

endpackage

// File: rtl/ftb_entry_ram.sv
// Slot storage: payload in an inferable RAM (one write, two synchronous
// read-first reads), valid flags in flops so reset can clear them at once.
module ftb_entry_ram #(
  parameter int IDX_W = 4,
  parameter int DW    = 66
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [DW-1:0]    ra_data,
  output logic             ra_valid,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [DW-1:0]    rb_data,
  output logic             rb_valid
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] slot_vld;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    ra_data <= mem[ra_idx];
    rb_data <= mem[rb_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld <= '0;
      ra_valid <= 1'b0;
      rb_valid <= 1'b0;
    end else begin
      if (wr_en) slot_vld[wr_idx] <= 1'b1;
      ra_valid <= slot_vld[ra_idx];
      rb_valid <= slot_vld[rb_idx];
    end
  end

endmodule

// File: rtl/ftb_fetch_port.sv
// Fetch-side lookup: index the RAM at the edge, compare the full tag after it.
module ftb_fetch_port #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [2*PC_W+CTR_W-1:0] rd_data,
  input  logic             rd_valid,
  output logic             lk_valid,
  output logic [PC_W-1:0]  lk_pc,
  output logic             lk_taken,
  output logic [PC_W-1:0]  lk_next_pc
);
  localparam int DW = 2*PC_W + CTR_W;

  logic            v_q;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] slot_tag;
  logic [PC_W-1:0] slot_tgt;
  logic [CTR_W-1:0] slot_ctr;

  assign rd_idx = fetch_pc[IDX_W+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q  <= 1'b0;
      pc_q <= '0;
    end else begin
      v_q  <= fetch_valid;
      pc_q <= fetch_pc;
    end
  end

  assign slot_tag = rd_data[DW-1 -: PC_W];
  assign slot_tgt = rd_data[PC_W+CTR_W-1 -: PC_W];
  assign slot_ctr = rd_data[CTR_W-1:0];

  always_comb begin
    lk_valid   = v_q;
    lk_pc      = pc_q;
    lk_taken   = v_q && rd_valid && (slot_tag == pc_q) && slot_ctr[CTR_W-1];
    lk_next_pc = lk_taken ? slot_tgt : pc_q + PC_W'(4);
  end

  // R3: every presented fetch yields a result one cycle later.
  a_r3_result_follows: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> lk_valid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !lk_valid);

endmodule

// File: rtl/ftb_resolve_unit.sv
// Resolution side: redirect decision in one stage, slot read-modify-write
// across two stages with forwarding of the write made one edge earlier.
module ftb_resolve_unit
  import ftb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rs_valid,
  input  logic [PC_W-1:0]  rs_pc,
  input  logic             rs_is_cti,
  input  logic             rs_taken,
  input  logic [PC_W-1:0]  rs_target,
  input  logic [PC_W-1:0]  rs_pred_next,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [2*PC_W+CTR_W-1:0] rd_data,
  input  logic             rd_valid,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [2*PC_W+CTR_W-1:0] wr_data,
  output logic             redir_valid,
  output logic [PC_W-1:0]  redir_pc
);
  localparam int DW = 2*PC_W + CTR_W;
  localparam logic [CTR_W-1:0] CTR_MAX   = '1;
  localparam logic [CTR_W-1:0] CTR_ALLOC = CTR_W'(1) << (CTR_W-1);

  // stage 1: captured report (control transfers only)
  logic            s1_v;
  logic [PC_W-1:0] s1_pc;
  logic            s1_taken;
  logic [PC_W-1:0] s1_target;

  // last write, for forwarding past the read-first RAM
  logic             fw_v;
  logic [IDX_W-1:0] fw_idx;
  logic [DW-1:0]    fw_data;

  logic [IDX_W-1:0] s1_idx;
  logic             fw_hit;
  logic [DW-1:0]    cur_data;
  logic             cur_vld;
  logic [PC_W-1:0]  cur_tag;
  logic [PC_W-1:0]  cur_tgt;
  logic [CTR_W-1:0] cur_ctr;
  logic             slot_hit;
  ftb_act_e         act;
  logic [CTR_W-1:0] new_ctr;
  logic [PC_W-1:0]  new_tgt;
  logic [PC_W-1:0]  actual_next;

  assign rd_idx = rs_pc[IDX_W+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s1_pc     <= '0;
      s1_taken  <= 1'b0;
      s1_target <= '0;
    end else begin
      s1_v      <= rs_valid && rs_is_cti;
      s1_pc     <= rs_pc;
      s1_taken  <= rs_taken;
      s1_target <= rs_target;
    end
  end

  always_comb begin
    s1_idx   = s1_pc[IDX_W+1:2];
    fw_hit   = fw_v && (fw_idx == s1_idx);
    cur_data = fw_hit ? fw_data : rd_data;
    cur_vld  = fw_hit || rd_valid;
    cur_tag  = cur_data[DW-1 -: PC_W];
    cur_tgt  = cur_data[PC_W+CTR_W-1 -: PC_W];
    cur_ctr  = cur_data[CTR_W-1:0];
    slot_hit = cur_vld && (cur_tag == s1_pc);

    if (!s1_v)         act = ACT_NONE;
    else if (slot_hit) act = ACT_TRAIN;
    else if (s1_taken) act = ACT_ALLOC;
    else               act = ACT_NONE;

    new_ctr = cur_ctr;
    new_tgt = cur_tgt;
    case (act)
      ACT_TRAIN: begin
        if (s1_taken) begin
          new_ctr = (cur_ctr == CTR_MAX) ? cur_ctr : cur_ctr + CTR_W'(1);
          new_tgt = s1_target;
        end else begin
          new_ctr = (cur_ctr == '0) ? cur_ctr : cur_ctr - CTR_W'(1);
        end
      end
      ACT_ALLOC: begin
        new_ctr = CTR_ALLOC;
        new_tgt = s1_target;
      end
      default: ;
    endcase

    wr_en   = (act != ACT_NONE);
    wr_idx  = s1_idx;
    wr_data = {s1_pc, new_tgt, new_ctr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fw_v    <= 1'b0;
      fw_idx  <= '0;
      fw_data <= '0;
    end else begin
      fw_v    <= wr_en;
      fw_idx  <= wr_idx;
      fw_data <= wr_data;
    end
  end

  // redirect: real next address against the one predicted at fetch
  assign actual_next = (rs_is_cti && rs_taken) ? rs_target : rs_pc + PC_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
    end else begin
      redir_valid <= rs_valid && (actual_next != rs_pred_next);
      redir_pc    <= actual_next;
    end
  end

  // R7: a non-control report reaches no write.
  a_r7_nonctrl_no_write: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !rs_is_cti) |=> !wr_en);
  // R5 / R8: a taken control transfer always trains or allocates.
  a_r5_taken_writes: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_is_cti && rs_taken) |=> wr_en);
  // R9: a redirect never points at the address that was already predicted.
  a_r9_redir_differs: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> (redir_pc != $past(rs_pred_next)));
  // R6: a not-taken report that misses leaves the table alone.
  a_r6_nt_miss_quiet: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !s1_taken && !slot_hit) |-> !wr_en);

endmodule

// File: rtl/fetch_target_buf.sv
module fetch_target_buf #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int CTR_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            lk_valid,
  output logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_next_pc,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_is_cti,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic [PC_W-1:0] rs_pred_next,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc
);
  localparam int DW = 2*PC_W + CTR_W;

  logic [IDX_W-1:0] fa_idx, rb_idx, wr_idx;
  logic [DW-1:0]    fa_data, rb_data, wr_data;
  logic             fa_vld, rb_vld, wr_en;

  ftb_entry_ram #(.IDX_W(IDX_W), .DW(DW)) u_ram (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ra_idx(fa_idx), .ra_data(fa_data), .ra_valid(fa_vld),
    .rb_idx(rb_idx), .rb_data(rb_data), .rb_valid(rb_vld)
  );

  ftb_fetch_port #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) u_fetch (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .rd_idx(fa_idx), .rd_data(fa_data), .rd_valid(fa_vld),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_next_pc(lk_next_pc)
  );

  ftb_resolve_unit #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) u_resolve (
    .clk(clk), .rst(rst),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_is_cti(rs_is_cti),
    .rs_taken(rs_taken), .rs_target(rs_target), .rs_pred_next(rs_pred_next),
    .rd_idx(rb_idx), .rd_data(rb_data), .rd_valid(rb_vld),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  // R2: a written tag always belongs to the slot it is written into.
  a_r2_tag_in_slot: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data[DW-1 -: PC_W] >> 2) % (1 << IDX_W) == PC_W'(wr_idx));

endmodule

// File: tb/test_fetch_target_buf.sv
`timescale 1ns/1ps
module test_fetch_target_buf;
  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int NSLOT = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_valid = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic lk_valid, lk_taken, redir_valid;
  logic [PC_W-1:0] lk_pc, lk_next_pc, redir_pc;
  logic rs_valid = 1'b0, rs_is_cti = 1'b0, rs_taken = 1'b0;
  logic [PC_W-1:0] rs_pc = '0, rs_target = '0, rs_pred_next = '0;

  always #2 clk = ~clk;  // 250 MHz

  fetch_target_buf #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(2)) i_fetch_target_buf (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_next_pc(lk_next_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_is_cti(rs_is_cti), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_pred_next(rs_pred_next),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // behavioural reference table
  bit              m_vld [NSLOT];
  logic [PC_W-1:0] m_tag [NSLOT];
  logic [PC_W-1:0] m_tgt [NSLOT];
  int              m_ctr [NSLOT];
  bit              p_v;
  logic [PC_W-1:0] p_pc, p_tg;
  bit              p_t;

  task automatic chk(input string tag, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int slot_of(input logic [PC_W-1:0] a);
    return int'(a[IDX_W+1:2]);
  endfunction

  function automatic logic [PC_W-1:0] model_next(input logic [PC_W-1:0] a);
    int ix = slot_of(a);
    if (m_vld[ix] && m_tag[ix] == a && m_ctr[ix] >= 2) return m_tgt[ix];
    return a + 4;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NSLOT; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 0;
    end
    p_v = 0;
  endtask

  task automatic model_write();
    int ix;
    if (!p_v) return;
    ix = slot_of(p_pc);
    if (m_vld[ix] && m_tag[ix] == p_pc) begin
      if (p_t) begin
        if (m_ctr[ix] < 3) m_ctr[ix]++;
        m_tgt[ix] = p_tg;
      end else if (m_ctr[ix] > 0) m_ctr[ix]--;
    end else if (p_t) begin
      m_vld[ix] = 1; m_tag[ix] = p_pc; m_tgt[ix] = p_tg; m_ctr[ix] = 2;
    end
  endtask

  // one clock: drive at negedge, predict, compare just after posedge
  task automatic step(input string tag,
                      input bit fv, input logic [PC_W-1:0] fpc,
                      input bit rv, input logic [PC_W-1:0] rpc, input bit rc,
                      input bit rt, input logic [PC_W-1:0] rtg,
                      input logic [PC_W-1:0] rpn);
    logic [PC_W-1:0] e_next, e_act;
    bit e_tk, e_rv;
    fetch_valid = fv; fetch_pc = fpc;
    rs_valid = rv; rs_pc = rpc; rs_is_cti = rc; rs_taken = rt;
    rs_target = rtg; rs_pred_next = rpn;
    e_next = model_next(fpc);
    e_tk   = (e_next != fpc + 4) ||
             (m_vld[slot_of(fpc)] && m_tag[slot_of(fpc)] == fpc && m_ctr[slot_of(fpc)] >= 2);
    e_act  = (rc && rt) ? rtg : rpc + 4;
    e_rv   = rv && (e_act != rpn);
    model_write();
    p_v = rv && rc; p_pc = rpc; p_t = rt; p_tg = rtg;
    @(posedge clk); #1;
    if (fv) chk(tag, "lookup valid/pc/taken/next",
                {lk_valid, lk_pc, lk_taken, lk_next_pc}, {1'b1, fpc, e_tk, e_next});
    else    chk(tag, "lookup idle", {95'd0, lk_valid}, 96'd0);
    if (e_rv) chk(tag, "redirect", {redir_valid, redir_pc}, {1'b1, e_act});
    else      chk(tag, "no redirect", {95'd0, redir_valid}, 96'd0);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    fetch_valid = 0; rs_valid = 0;
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {94'd0, lk_valid, redir_valid}, 96'd0);
    rst = 1'b0;
  endtask

  localparam logic [PC_W-1:0] A = 32'h100;   // slot 0
  localparam logic [PC_W-1:0] B = 32'h140;   // also slot 0, other tag

  initial begin
    @(negedge clk);
    do_reset();
    step("R1", 1, A, 0, 0, 0, 0, 0, 0);                    // empty: A+4
    step("R9", 0, 0, 1, A, 1, 1, 32'h400, A + 4);          // wrong: redirect 0x400
    step("R10", 1, A, 0, 0, 0, 0, 0, 0);                   // write lands now: old view
    step("R5", 1, A, 0, 0, 0, 0, 0, 0);                    // allocated weak taken: 0x400
    step("R3", 1, A, 0, 0, 0, 0, 0, 0);
    step("R2", 1, B, 0, 0, 0, 0, 0, 0);                    // alias misses
    step("R6", 0, 0, 1, B, 1, 0, 0, B + 4);                // not-taken miss: no write
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 1, A, 0, 0, 0, 0, 0, 0);                    // A still there
    step("R6", 1, B, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 1, A, 0, 1, 32'h999, A + 4);          // non-control: no change
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R7", 1, A, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 1, A, 0, 0, 0, 32'h400);              // non-control redirect to A+4
    step("R8", 0, 0, 1, A, 1, 0, 0, 32'h400);              // 10 -> 01, redirect
    step("R10", 0, 0, 1, A, 1, 0, 0, A + 4);               // forwarded: 01 -> 00
    step("R8", 0, 0, 1, A, 1, 0, 0, A + 4);                // saturate at 00
    step("R4", 1, A, 0, 0, 0, 0, 0, 0);                    // hit, not taken
    step("R8", 0, 0, 1, A, 1, 1, 32'h480, A + 4);          // 00 -> 01
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 1, A, 0, 0, 0, 0, 0, 0);                    // still A+4
    step("R8", 0, 0, 1, A, 1, 1, 32'h480, A + 4);          // 01 -> 10
    step("R8", 0, 0, 1, A, 1, 1, 32'h480, 32'h480);        // 10 -> 11
    step("R8", 0, 0, 1, A, 1, 1, 32'h4C0, 32'h480);        // saturate, new target
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 1, A, 0, 0, 0, 0, 0, 0);                    // 0x4C0

    for (int n = 0; n < 4000; n++) begin
      logic [PC_W-1:0] fa, ra, tg, pn;
      int sel;
      fa = 32'h100 + 4 * ($urandom % 8) + (($urandom % 2) != 0 ? 32'h40 : 32'h0);
      ra = 32'h100 + 4 * ($urandom % 8) + (($urandom % 2) != 0 ? 32'h40 : 32'h0);
      tg = 32'h800 + 4 * ($urandom % 6);
      sel = int'($urandom % 3);
      pn = (sel == 0) ? model_next(ra) : ((sel == 1) ? ra + 4 : tg);
      step("R10", ($urandom % 4) != 0, fa, ($urandom % 3) != 0, ra,
           ($urandom % 5) != 0, ($urandom % 2) != 0, tg, pn);
    end

    do_reset();
    step("R1", 1, A, 0, 0, 0, 0, 0, 0);
    step("R1", 1, B, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule